// File: doc/BRIEF.md
# Prescaled Timer with Two-Level Enable

This block is one 16-bit up-counting timer channel. A prescaler divides the system clock by a power of two from 4 to 512 to make a count tick. On each tick the counter steps up by one and wraps to zero after reaching a programmable period. A single pulse output sits at its active level while the count is below a programmable compare value, and at its inactive level otherwise. A control bit sets the output polarity.

Two enables govern the channel. The clock-action enable resets the whole unit when it is low. This covers the prescaler, the counter and every setting register. Clearing it wipes all settings, so software must program them again. Reset is applied asynchronously when the bit goes low. It is released synchronously, one clock edge after the bit goes high. The count enable only starts and stops counting. While it is low, the counter and the prescaler are held at zero and the output is forced inactive. The divider select can only be changed while the channel is stopped. Writes to it during counting are dropped.

The channel is programmed through a small write port. Address 0 is the control register: bit 0 is the clock-action enable, bit 1 the count enable, bit 2 the active level (1 means active high), and bits 6:4 the divider code. Address 1 is the period register and address 2 is the compare register.

Top module: `pulse_timer`

## Requirements
- R1: With divider code k (control bits 6:4), the count advances once every 4·2^k clock cycles, so codes 0 to 7 give 4 to 512. The first increment appears exactly 4·2^k clock edges after the edge that accepts the write setting the count enable.
- R2: While the count enable is 0, the count reads 0. It is 0 from the first edge after the stopping write.
- R3: While the count enable is 0, pulse_out equals the complement of the active-level bit.
- R4: While counting, pulse_out equals the active-level bit when the count is below the compare register, and its complement otherwise.
- R5: The count goes up by one per tick and returns to 0 on the tick after it equals the period register.
- R6: While the clock-action enable is 0, the unit is in reset. The count is 0, pulse_out is 1, and writes to the period and compare registers are ignored.
- R7: Clearing the clock-action enable returns every unit setting to its initial value: period FFFFh, compare 0, active level 0, divider code 0 and count enable 0.
- R8: While the count enable is 1, a control write leaves the divider code unchanged. Its other fields still take effect.
- R9: After the write that sets the clock-action enable, the next write on the following edge is ignored. Writes are accepted from the second edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Chip reset, active low, clears the clock-action enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 period, 2 compare |
| wr_data | input | 16 | Write data |
| pulse_out | output | 1 | Timer pulse output |
| count_o | output | 16 | Current counter value |

## Verification
On every cycle, the embedded properties check several invariants. The count stays at zero and the output stays inactive while the channel is stopped. The count only ever steps up by one or returns to zero. The prescaler stays inside the selected division, and the divider code is frozen while counting. The whole unit sits idle while the clock-action enable is low. The directed scenarios are needed for the rest. They measure the exact tick spacing for all eight divider codes and follow the compare and wrap pattern through several periods under both polarities. They also show that settings are wiped across a clock-action cycle, and that writes are dropped on the edge right after re-enabling and accepted one edge later.

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 3,
  parameter int MIN_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pulse_out,
  output logic [CNT_W-1:0] count_o
);
  localparam int PRE_W = MIN_LOG2 + (1 << SEL_W) - 1;
  localparam logic [PRE_W-1:0] PRE_ONES = '1;
  localparam logic [SEL_W-1:0] SEL_MAX  = '1;
  localparam logic [1:0] A_CTRL = 2'd0, A_PER = 2'd1, A_CMP = 2'd2;

  logic             cae_q, live_q, run_q, pol_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] per_q, cmp_q, cnt_q;
  logic [PRE_W-1:0] pre_q, div_m1;
  logic             tick, core_arst_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cae_q <= 1'b0;
    else if (wr_en && wr_addr == A_CTRL) cae_q <= wr_data[0];

  assign core_arst_n = rst_n & cae_q;

  always_ff @(posedge clk or negedge core_arst_n)
    if (!core_arst_n) live_q <= 1'b0;
    else live_q <= 1'b1;

  always_ff @(posedge clk or negedge live_q)
    if (!live_q) begin
      run_q <= 1'b0;
      pol_q <= 1'b0;
      sel_q <= '0;
      per_q <= '1;
      cmp_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run_q <= wr_data[1];
          pol_q <= wr_data[2];
          if (!run_q) sel_q <= wr_data[4 +: SEL_W];
        end
        A_PER:   per_q <= wr_data;
        A_CMP:   cmp_q <= wr_data;
        default: ;
      endcase
    end

  assign div_m1 = PRE_ONES >> (SEL_MAX - sel_q);
  assign tick   = run_q && (pre_q == div_m1);

  always_ff @(posedge clk or negedge live_q)
    if (!live_q)     pre_q <= '0;
    else if (!run_q) pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge live_q)
    if (!live_q)     cnt_q <= '0;
    else if (!run_q) cnt_q <= '0;
    else if (tick)   cnt_q <= (cnt_q == per_q) ? '0 : cnt_q + 1'b1;

  assign count_o   = cnt_q;
  assign pulse_out = (run_q && cnt_q < cmp_q) ? pol_q : ~pol_q;

  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!live_q)
    pre_q <= div_m1);

  assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!live_q)
    !run_q |=> (count_o == '0));

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!live_q)
    !run_q |-> (pulse_out == !pol_q));

  assert_step_R5: assert property (@(posedge clk) disable iff (!live_q)
    (run_q && $past(run_q) && count_o != $past(count_o))
      |-> (count_o == $past(count_o) + 1'b1 || count_o == '0));

  assert_unit_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cae_q |-> (count_o == '0 && pulse_out));

  assert_sel_locked_R8: assert property (@(posedge clk) disable iff (!live_q)
    $past(run_q) |-> $stable(sel_q));
endmodule

// File: tb/tb_pulse_timer.sv
module tb_pulse_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pulse_out;
  logic [15:0] count_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pulse_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                   .wr_data(wr_data), .pulse_out(pulse_out), .count_o(count_o));

  function automatic logic [15:0] ctl(input int sel, input bit run, input bit pol);
    return 16'(1 | (int'(run) << 1) | (int'(pol) << 2) | (sel << 4));
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R6 reset count", count_o, 0);
    chk("R6 reset out", pulse_out, 1);
    wr(2'd1, 16'd2);
    chk("R6 count while unit off", count_o, 0);
    wr(2'd0, 16'd1);
    step(1);
  endtask

  task automatic t_divs;
    for (int s = 0; s < 8; s++) begin
      int d = 4 << s;
      wr(2'd0, ctl(s, 0, 0));
      wr(2'd0, ctl(s, 1, 0));
      step(d - 1);
      chk($sformatf("R1 code %0d before tick", s), count_o, 0);
      step(1);
      chk($sformatf("R1 code %0d first tick", s), count_o, 1);
      wr(2'd0, ctl(s, 0, 0));
      step(1);
      chk("R2 stopped count", count_o, 0);
      chk("R3 stopped out pol0", pulse_out, 1);
    end
  endtask

  task automatic t_wrap;
    wr(2'd0, ctl(0, 0, 1));
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd2);
    chk("R3 stopped out pol1", pulse_out, 0);
    wr(2'd0, ctl(0, 1, 1));
    chk("R4 start count", count_o, 0);
    chk("R4 start out", pulse_out, 1);
    for (int m = 1; m <= 8; m++) begin
      step(4);
      chk("R5 wrap count", count_o, m % 4);
      chk("R4 compare out", pulse_out, (m % 4) < 2 ? 1 : 0);
    end
    wr(2'd0, ctl(0, 0, 1));
  endtask

  task automatic t_pol;
    wr(2'd0, ctl(0, 0, 0));
    step(1);
    chk("R3 stopped out pol0", pulse_out, 1);
    wr(2'd0, ctl(0, 1, 0));
    step(4);
    chk("R4 active low count", count_o, 1);
    chk("R4 active low out", pulse_out, 0);
    step(4);
    chk("R4 inactive high out", pulse_out, 1);
    wr(2'd0, ctl(0, 0, 0));
  endtask

  task automatic t_lock;
    wr(2'd0, ctl(0, 1, 1));
    step(2);
    wr(2'd0, ctl(7, 1, 1));
    step(1);
    chk("R8 first tick kept div4", count_o, 1);
    step(4);
    chk("R8 second tick kept div4", count_o, 2);
    wr(2'd0, ctl(7, 0, 1));
    wr(2'd0, ctl(0, 1, 1));
    step(4);
    chk("R8 restart div4", count_o, 1);
  endtask

  task automatic t_cae;
    step(3);
    wr(2'd0, 16'd0);
    chk("R6 count after clear", count_o, 0);
    chk("R6 out after clear", pulse_out, 1);
    wr(2'd1, 16'd2);
    step(3);
    chk("R6 count stays 0", count_o, 0);
    wr(2'd0, 16'd1);
    wr(2'd2, 16'd5);
    wr(2'd0, ctl(0, 1, 1));
    chk("R9 early compare write dropped", pulse_out, 0);
    step(16);
    chk("R7 period reinitialised", count_o, 4);
    wr(2'd0, 16'd0);
    wr(2'd0, 16'd1);
    step(1);
    wr(2'd2, 16'd5);
    wr(2'd0, ctl(0, 1, 1));
    chk("R9 second-edge write accepted", pulse_out, 1);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_divs();
    t_wrap();
    t_pol();
    t_lock();
    t_cae();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule